// File: doc/BRIEF.md
# Ethernet MAC Transmit Status Tracker

This block keeps the per-packet transmit status of a 10/100 Ethernet MAC. A transmit engine reports what happens to each frame through single-cycle strobes: a packet attempt starts, a collision occurs, the attempt is deferred, the packet ends successfully, or the SQE heartbeat was or was not seen. The MAC also reports a received PAUSE frame and a software request to send one. Configuration levels select transmit enable, SQE checking, duplex and line speed.

From these inputs the block keeps a consecutive-collision counter, an abort flag and four condition flags: deferred, SQE error, paused and halted. It presents them as one status word that software can read. It also drives a single grant that tells the transmit engine whether the next normal packet may begin. Sticky flags are cleared by a write-one-to-clear pulse vector that uses the same bit positions as the status word. The MII, the backoff timer and the CRC logic sit outside the block and reach it only as event strobes.

Status word layout, with the default 4-bit counter: bit 0 abort, bits 4:1 collision count, bit 5 deferred, bit 6 SQE error, bit 7 paused, bit 8 halted. Every output is registered, so an event applied before a clock edge shows up in the status after that edge.

Top module: `txstat_tracker`

## Requirements
- R1: While a packet is in progress, each collision strobe adds one to the collision count in status bits 4:1.
- R2: A collision that arrives while the count is 15 leaves the count at 0, sets abort (bit 0) and ends the packet. Further collisions are ignored until the next start strobe.
- R3: Deferred (bit 5) is set by a defer strobe during a packet only in half duplex. In full duplex the strobe has no effect.
- R4: SQE error (bit 6) is set at a successful packet end with no SQE seen, but only when SQE checking is enabled and the link runs half duplex at 10 Mb/s.
- R5: Paused (bit 7) is set by a received PAUSE frame or by a software pause request. It is cleared by the pause-expiry strobe or by a write-one-to-clear. A set in the same cycle as a clear wins.
- R6: Halted (bit 8) is high whenever transmit enable is low and no packet is in progress. A packet in progress runs to its end first, and halted drops once transmit enable returns high.
- R7: A start strobe clears the collision count, abort, deferred and SQE error. Any collision, defer or end strobe given in that same cycle is ignored.
- R8: A 1 written into bit 0, 5, 6 or 7 of the clear vector clears that flag. Writing a 1 into the halted bit or the count bits has no effect.
- R9: The grant output is high exactly when neither halted nor paused is set.
- R10: After reset the status word is all zeros and grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit enable level |
| cfg_sqe_en | input | 1 | SQE check enable |
| cfg_full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| cfg_speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| ev_start | input | 1 | A packet attempt begins |
| ev_collision | input | 1 | Collision seen on the current attempt |
| ev_defer | input | 1 | Current attempt deferred |
| ev_end | input | 1 | Packet completed successfully |
| ev_sqe_seen | input | 1 | SQE heartbeat seen, sampled with ev_end |
| ev_pause_rx | input | 1 | PAUSE control frame received |
| sw_pause_req | input | 1 | Software request to send a PAUSE frame |
| pause_expire | input | 1 | Pause duration elapsed |
| sw_w1c | input | 9 | Write-one-to-clear vector, laid out like the status word |
| status_o | output | 9 | Status word |
| tx_grant_o | output | 1 | Next normal packet may start |

## Verification
A table of cycle-by-cycle vectors first drives one ordinary packet life: start, collisions mixed with a defer, and an end with SQE present. This separates counting from flag setting. A second packet ends without SQE, which shows that the check fires only at a successful end. Pause is raised by each of its two sources and dropped by each of its two exits, so a swapped or missing path changes the grant on a known cycle. Directed runs then cover the sixteenth collision, halting while a packet is in flight, full-duplex defer, 100 Mb/s and disabled SQE checks, a set against a clear in one cycle, and a clear written into the halted bit.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
    localparam int DEF_CCNT_W = 4;

    typedef struct packed {
        logic deferred;
        logic sqe_err;
        logic paused;
        logic halted;
    } flags_t;
endpackage

// File: rtl/txstat_coll.sv
module txstat_coll #(
    parameter int CCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_collision,
    input  logic              ev_end,
    input  logic              clr_abort,
    output logic [CCNT_W-1:0] cnt_o,
    output logic              abort_o,
    output logic              in_pkt_q_o,
    output logic              in_pkt_d_o,
    output logic              end_ok_o
);
    localparam logic [CCNT_W-1:0] CNT_MAX = {CCNT_W{1'b1}};

    typedef struct packed {
        logic              in_pkt;
        logic [CCNT_W-1:0] cnt;
        logic              abort;
    } coll_t;

    coll_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ev_start) begin
            st_d.in_pkt = 1'b1;
            st_d.cnt    = '0;
            st_d.abort  = 1'b0;
        end else begin
            if (clr_abort) st_d.abort = 1'b0;
            if (st_q.in_pkt && ev_collision) begin
                if (st_q.cnt == CNT_MAX) begin
                    st_d.cnt    = '0;
                    st_d.abort  = 1'b1;
                    st_d.in_pkt = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + CCNT_W'(1);
                end
            end else if (st_q.in_pkt && ev_end) begin
                st_d.in_pkt = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o      = st_q.cnt;
    assign abort_o    = st_q.abort;
    assign in_pkt_q_o = st_q.in_pkt;
    assign in_pkt_d_o = st_d.in_pkt;
    assign end_ok_o   = !ev_start && st_q.in_pkt && ev_end && !ev_collision;

    // R1: a collision below the limit advances the count by one
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_start && in_pkt_q_o && ev_collision && cnt_o != CNT_MAX)
        |=> (cnt_o == $past(cnt_o) + CCNT_W'(1)));

    // R2: the collision at the limit wraps to zero, aborts and ends the packet
    assert_wrap_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_start && in_pkt_q_o && ev_collision && cnt_o == CNT_MAX)
        |=> (cnt_o == '0 && abort_o && !in_pkt_q_o));

    // R7: a start strobe empties the count and abort
    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (cnt_o == '0 && !abort_o && in_pkt_q_o));
endmodule

// File: rtl/txstat_flags.sv
module txstat_flags
    import txstat_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cfg_tx_en,
    input  logic   cfg_sqe_en,
    input  logic   cfg_full_duplex,
    input  logic   cfg_speed_100,
    input  logic   ev_start,
    input  logic   ev_defer,
    input  logic   ev_sqe_seen,
    input  logic   ev_pause_rx,
    input  logic   sw_pause_req,
    input  logic   pause_expire,
    input  logic   in_pkt_q,
    input  logic   in_pkt_d,
    input  logic   end_ok,
    input  logic   clr_def,
    input  logic   clr_sqe,
    input  logic   clr_pause,
    output flags_t flags_o
);
    flags_t fl_d, fl_q;
    logic   sqe_window;

    assign sqe_window = cfg_sqe_en && !cfg_full_duplex && !cfg_speed_100;

    always_comb begin
        fl_d = fl_q;

        if (ev_start)                                    fl_d.deferred = 1'b0;
        else if (in_pkt_q && ev_defer && !cfg_full_duplex) fl_d.deferred = 1'b1;
        else if (clr_def)                                fl_d.deferred = 1'b0;

        if (ev_start)                                    fl_d.sqe_err = 1'b0;
        else if (end_ok && sqe_window && !ev_sqe_seen)   fl_d.sqe_err = 1'b1;
        else if (clr_sqe)                                fl_d.sqe_err = 1'b0;

        if (ev_pause_rx || sw_pause_req)                 fl_d.paused = 1'b1;
        else if (pause_expire || clr_pause)              fl_d.paused = 1'b0;

        fl_d.halted = !cfg_tx_en && !in_pkt_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags_o = fl_q;

    // R3: full duplex never raises deferred
    assert_fd_no_defer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_full_duplex && !flags_o.deferred) |=> !flags_o.deferred);

    // R4: outside the 10 Mb/s half-duplex window the SQE flag never rises
    assert_sqe_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sqe_window && !flags_o.sqe_err) |=> !flags_o.sqe_err);

    // R5: either pause source sets paused on the next cycle
    assert_pause_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pause_rx || sw_pause_req) |=> flags_o.paused);

    // R6: enable low with no packet in flight gives halted
    assert_halt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_tx_en && !in_pkt_q && !ev_start) |=> flags_o.halted);
endmodule

// File: rtl/txstat_tracker.sv
module txstat_tracker
    import txstat_pkg::*;
#(
    parameter int CCNT_W = DEF_CCNT_W,
    localparam int STAT_W = CCNT_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_en,
    input  logic              cfg_sqe_en,
    input  logic              cfg_full_duplex,
    input  logic              cfg_speed_100,
    input  logic              ev_start,
    input  logic              ev_collision,
    input  logic              ev_defer,
    input  logic              ev_end,
    input  logic              ev_sqe_seen,
    input  logic              ev_pause_rx,
    input  logic              sw_pause_req,
    input  logic              pause_expire,
    input  logic [STAT_W-1:0] sw_w1c,
    output logic [STAT_W-1:0] status_o,
    output logic              tx_grant_o
);
    localparam int B_ABORT = 0;
    localparam int B_DEF   = CCNT_W + 1;
    localparam int B_SQE   = CCNT_W + 2;
    localparam int B_PAUSE = CCNT_W + 3;
    localparam int B_HALT  = CCNT_W + 4;

    logic [CCNT_W-1:0] cnt;
    logic              abort;
    logic              in_pkt_q, in_pkt_d, end_ok;
    flags_t            flags;

    txstat_coll #(.CCNT_W(CCNT_W)) coll_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_start     (ev_start),
        .ev_collision (ev_collision),
        .ev_end       (ev_end),
        .clr_abort    (sw_w1c[B_ABORT]),
        .cnt_o        (cnt),
        .abort_o      (abort),
        .in_pkt_q_o   (in_pkt_q),
        .in_pkt_d_o   (in_pkt_d),
        .end_ok_o     (end_ok)
    );

    txstat_flags flags_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_tx_en       (cfg_tx_en),
        .cfg_sqe_en      (cfg_sqe_en),
        .cfg_full_duplex (cfg_full_duplex),
        .cfg_speed_100   (cfg_speed_100),
        .ev_start        (ev_start),
        .ev_defer        (ev_defer),
        .ev_sqe_seen     (ev_sqe_seen),
        .ev_pause_rx     (ev_pause_rx),
        .sw_pause_req    (sw_pause_req),
        .pause_expire    (pause_expire),
        .in_pkt_q        (in_pkt_q),
        .in_pkt_d        (in_pkt_d),
        .end_ok          (end_ok),
        .clr_def         (sw_w1c[B_DEF]),
        .clr_sqe         (sw_w1c[B_SQE]),
        .clr_pause       (sw_w1c[B_PAUSE]),
        .flags_o         (flags)
    );

    always_comb begin
        status_o                = '0;
        status_o[B_ABORT]       = abort;
        status_o[CCNT_W:1]      = cnt;
        status_o[B_DEF]         = flags.deferred;
        status_o[B_SQE]         = flags.sqe_err;
        status_o[B_PAUSE]       = flags.paused;
        status_o[B_HALT]        = flags.halted;
    end

    assign tx_grant_o = !(flags.halted || flags.paused);

    // R8: a clear of the halted bit leaves halted set while enable stays low and no packet runs
    assert_halt_not_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[B_HALT] && sw_w1c[B_HALT] && !cfg_tx_en && !ev_start && !in_pkt_q)
        |=> status_o[B_HALT]);

    // R9: a paused flag from the flag unit always withholds the grant
    assert_pause_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags.paused |-> !tx_grant_o);
endmodule

// File: tb/txstat_tracker_tb_top.sv
`timescale 1ns/1ps
module txstat_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [11:0] in_v = 12'b1100_0000_0000;
    logic [8:0] w1c = '0;
    logic [8:0] status;
    logic       grant;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    txstat_tracker dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_tx_en       (in_v[11]),
        .cfg_sqe_en      (in_v[10]),
        .cfg_full_duplex (in_v[9]),
        .cfg_speed_100   (in_v[8]),
        .ev_start        (in_v[7]),
        .ev_collision    (in_v[6]),
        .ev_defer        (in_v[5]),
        .ev_end          (in_v[4]),
        .ev_sqe_seen     (in_v[3]),
        .ev_pause_rx     (in_v[2]),
        .sw_pause_req    (in_v[1]),
        .pause_expire    (in_v[0]),
        .sw_w1c          (w1c),
        .status_o        (status),
        .tx_grant_o      (grant)
    );

    // {inputs[11:0], w1c[8:0], expected status[8:0], expected grant}
    // inputs: tx_en sqe_en fdx spd100 | start coll defer end | sqe_seen prx swp expire
    localparam int NV = 14;
    localparam logic [30:0] VEC [NV] = '{
        {12'b1100_1000_0000, 9'h000, 9'h000, 1'b1},  // R7 start
        {12'b1100_0100_0000, 9'h000, 9'h002, 1'b1},  // R1 count 1
        {12'b1100_0110_0000, 9'h000, 9'h024, 1'b1},  // R1 R3 count 2 + deferred
        {12'b1100_0001_1000, 9'h000, 9'h024, 1'b1},  // R4 end, SQE seen
        {12'b1100_0000_0000, 9'h020, 9'h004, 1'b1},  // R8 clear deferred
        {12'b1100_1000_0000, 9'h000, 9'h000, 1'b1},  // R7 start clears count
        {12'b1100_0001_0000, 9'h000, 9'h040, 1'b1},  // R4 end, SQE missing
        {12'b1100_0000_0100, 9'h000, 9'h0C0, 1'b0},  // R5 R9 pause rx
        {12'b1100_0000_0001, 9'h000, 9'h040, 1'b1},  // R5 expiry
        {12'b1100_0000_0010, 9'h040, 9'h080, 1'b0},  // R5 R8 sw pause, clear SQE
        {12'b1100_0000_0000, 9'h080, 9'h000, 1'b1},  // R5 R8 clear paused
        {12'b0100_0000_0000, 9'h000, 9'h100, 1'b0},  // R6 R9 halted idle
        {12'b0100_0000_0000, 9'h100, 9'h100, 1'b0},  // R8 clear of halted ignored
        {12'b1100_0000_0000, 9'h000, 9'h000, 1'b1}   // R6 enable back
    };

    task automatic check(input string req, input logic [8:0] exp_s, input logic exp_g);
        checks++;
        if (status !== exp_s || grant !== exp_g) begin
            errors++;
            $display("FAIL %s: status=%h grant=%b expected status=%h grant=%b",
                     req, status, grant, exp_s, exp_g);
        end
    endtask

    // apply at negedge, sampled at posedge, checked at the following negedge
    task automatic step(input logic [11:0] iv, input logic [8:0] wc);
        in_v = iv;
        w1c  = wc;
        @(negedge clk);
        in_v = iv & 12'b1111_0000_0000;
        w1c  = '0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R10 reset", 9'h000, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", 9'h000, 1'b1);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][30:19], VEC[i][18:10]);
            check($sformatf("vector %0d", i), VEC[i][9:1], VEC[i][0]);
        end

        // R2: sixteen consecutive collisions
        step(12'b1100_1000_0000, 9'h000);
        for (int k = 1; k <= 15; k++) step(12'b1100_0100_0000, 9'h000);
        check("R1 count at 15", 9'h01E, 1'b1);
        step(12'b1100_0100_0000, 9'h000);
        check("R2 wrap and abort", 9'h001, 1'b1);
        step(12'b1100_0100_0000, 9'h000);
        check("R2 collision after abort ignored", 9'h001, 1'b1);
        step(12'b1100_0000_0000, 9'h001);
        check("R8 clear abort", 9'h000, 1'b1);

        // R7: events in the start cycle are ignored
        step(12'b1100_1110_0000, 9'h000);
        check("R7 same-cycle events ignored", 9'h000, 1'b1);

        // R6: disable during a packet waits for its end
        step(12'b0100_0000_0000, 9'h000);
        check("R6 in-flight packet not halted", 9'h000, 1'b1);
        step(12'b0100_0001_1000, 9'h000);
        check("R6 halted after end", 9'h100, 1'b0);
        step(12'b1100_0000_0000, 9'h000);
        check("R6 halt released", 9'h000, 1'b1);

        // R3: full duplex ignores defer
        step(12'b1110_1000_0000, 9'h000);
        step(12'b1110_0010_0000, 9'h000);
        check("R3 full-duplex defer ignored", 9'h000, 1'b1);
        // R4: full duplex skips the SQE check
        step(12'b1110_0001_0000, 9'h000);
        check("R4 full duplex no SQE error", 9'h000, 1'b1);

        // R4: 100 Mb/s skips the SQE check
        step(12'b1101_1000_0000, 9'h000);
        step(12'b1101_0001_0000, 9'h000);
        check("R4 100M no SQE error", 9'h000, 1'b1);

        // R4: disabled SQE check
        step(12'b1000_1000_0000, 9'h000);
        step(12'b1000_0001_0000, 9'h000);
        check("R4 SQE check disabled", 9'h000, 1'b1);

        // R5: set beats clear in the same cycle
        step(12'b1100_0000_0100, 9'h080);
        check("R5 set wins over clear", 9'h080, 1'b0);
        step(12'b1100_0000_0001, 9'h000);
        check("R5 expiry ends pause", 9'h000, 1'b1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule